// File: doc/BRIEF.md
# Single-Channel Bus-Master Transfer Engine

This block moves a run of data words between a peripheral's local data port and a simple request/acknowledge memory port. It needs no processor involvement once started. Software programs it through a byte-wide register window. The window holds a command register, a status register, a transfer start address and a transfer length. The address and the length are multi-byte registers. Each is written one byte at a time, with the least significant byte at the lowest offset.

To run a transfer, software first writes the stop command, which opens the configuration. It then picks the direction with a direction command, loads the address and the word count, and writes the go command. In the memory-write direction, the engine takes each word from the peripheral source port and stores it to memory. In the memory-read direction, it fetches each word from memory and hands it to the peripheral sink port. The address and length registers act as live counters while the transfer runs. When the count reaches zero, a level interrupt is raised. The interrupt stays up until software clears it.

Top module: `bm_dma_engine`

## Requirements
- R1: After reset, irq, mem_req, src_ready and snk_valid are low, the status byte reads 0, and the address and length registers read 0.
- R2: Pointer registers are written and read per byte, little-endian. For the address register (offsets 4..7) and the length register (offsets 8..11), the byte at base+i maps to bits [8i+7:8i].
- R3: Writes to the address, the length, or the direction are ignored unless two conditions hold: the stop command (8'h01) has been written since the last accepted go, and no transfer is running. Writes that arrive after reset but before any stop command are also ignored.
- R4: Writing the go command (8'h02) to offset 0 starts a transfer only under the same open-and-idle condition. A go that arrives while a transfer runs, or after completion without a new stop, is ignored. Writing the address or length never starts a transfer.
- R5: In the memory-write direction (command 8'h04, the default after reset), each word accepted on the source port (src_valid and src_ready high at a clock edge) is stored with mem_we high. While mem_req waits for mem_ack, mem_req, mem_we, mem_addr and mem_wdata stay unchanged. At most one of src_ready, mem_req and snk_valid is high at a time.
- R6: In the memory-read direction (command 8'h08), each word is read with mem_we low. The word returned with mem_ack is then held on snk_data, with snk_valid high, until snk_ready.
- R7: Each completed word adds DATA_W/8 to the address register and subtracts one from the length register. Memory accesses use consecutive addresses starting at the programmed address.
- R8: When the length reaches zero, irq rises one clock after the last word's final handshake, with the engine idle. A zero length raises irq one clock after the go is accepted, with no memory access.
- R9: irq stays high until a register write to offset 1 has bit 1 set. A write to offset 1 with bit 1 clear leaves irq unchanged.
- R10: A stop command written during a transfer ends it at the next word boundary without raising irq. The length and address registers then show the words not yet moved and the next address. If the length has already reached zero, completion takes priority.
- R11: The status byte at offset 1 has four bits. Bit 0 is busy, high from the accepted go until the engine is idle again. Bit 1 is the interrupt, bit 2 is the direction (1 = memory read), and bit 3 is set while the configuration is open.
- R12: Command codes other than 8'h01, 8'h02, 8'h04 and 8'h08 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset for writes and reads |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Register read byte at reg_addr |
| irq | output | 1 | Completion interrupt, level |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory request is a write |
| mem_addr | output | PTR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write word |
| mem_ack | input | 1 | Memory request completed |
| mem_rdata | input | DATA_W | Memory read word, valid with mem_ack |
| src_valid | input | 1 | Peripheral source has a word |
| src_data | input | DATA_W | Peripheral source word |
| src_ready | output | 1 | Engine takes the source word |
| snk_valid | output | 1 | Engine offers a word to the peripheral |
| snk_data | output | DATA_W | Word to the peripheral |
| snk_ready | input | 1 | Peripheral takes the word |

## Verification
The bench builds the engine with 32-bit words, 32-bit pointers and a 4-bit register offset. Each word therefore steps the address by four, and each pointer spans four byte lanes. A transfer that starts at 0xFC makes the address carry out of the low byte lane, so the little-endian readback is checked across lanes as well as within one. A slow sink and a dry source keep the engine waiting in both word-boundary states, which lets a stop command land while a word is still pending.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

   // register window byte offsets
   localparam int CMD_OFS  = 0;
   localparam int STAT_OFS = 1;
   localparam int ADDR_OFS = 4;
   localparam int LEN_OFS  = 8;

   // command codes
   localparam logic [7:0] OP_STOP     = 8'h01;
   localparam logic [7:0] OP_GO       = 8'h02;
   localparam logic [7:0] OP_TO_MEM   = 8'h04;
   localparam logic [7:0] OP_FROM_MEM = 8'h08;

   // status bit positions
   localparam int ST_BUSY_BIT = 0;
   localparam int ST_IRQ_BIT  = 1;
   localparam int ST_DIR_BIT  = 2;
   localparam int ST_OPEN_BIT = 3;

   typedef enum logic [2:0] {
      XS_IDLE,
      XS_DECIDE,
      XS_FETCH,
      XS_MEM,
      XS_DELIVER
   } xfer_state_t;

endpackage

// File: rtl/bmd_ctl_regs.sv
module bmd_ctl_regs import bmd_pkg::*; #(
   parameter int REG_AW = 4,
   parameter int PTR_W  = 32,
   localparam int NB    = PTR_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   input  logic              busy,
   input  logic              done,
   output logic              start,
   output logic              stop_req,
   output logic              dir_m2d,
   output logic              cfg_open,
   output logic              irq,
   output logic [NB-1:0]     addr_we,
   output logic [NB-1:0]     len_we
);

   logic wr_cmd, wr_stat, cfg_ok;

   assign wr_cmd  = reg_wr && (reg_addr == REG_AW'(CMD_OFS));
   assign wr_stat = reg_wr && (reg_addr == REG_AW'(STAT_OFS));
   assign cfg_ok  = cfg_open && !busy;
   assign start   = wr_cmd && (reg_wdata == OP_GO) && cfg_ok;

   for (genvar i = 0; i < NB; i++) begin : g_lane_we
      assign addr_we[i] = reg_wr && cfg_ok && (reg_addr == REG_AW'(ADDR_OFS + i));
      assign len_we[i]  = reg_wr && cfg_ok && (reg_addr == REG_AW'(LEN_OFS + i));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_open <= 1'b0;
         dir_m2d  <= 1'b0;
         stop_req <= 1'b0;
         irq      <= 1'b0;
      end else begin
         if (wr_cmd && reg_wdata == OP_STOP)
            cfg_open <= 1'b1;
         else if (start)
            cfg_open <= 1'b0;

         if (wr_cmd && cfg_ok && reg_wdata == OP_TO_MEM)
            dir_m2d <= 1'b0;
         else if (wr_cmd && cfg_ok && reg_wdata == OP_FROM_MEM)
            dir_m2d <= 1'b1;

         if (start)
            stop_req <= 1'b0;
         else if (wr_cmd && reg_wdata == OP_STOP && busy)
            stop_req <= 1'b1;
         else if (!busy)
            stop_req <= 1'b0;

         if (done)
            irq <= 1'b1;
         else if (wr_stat && reg_wdata[ST_IRQ_BIT])
            irq <= 1'b0;
      end
   end

endmodule

// File: rtl/bmd_ptr_regs.sv
module bmd_ptr_regs #(
   parameter int PTR_W = 32,
   parameter int STEP  = 4,
   localparam int NB   = PTR_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NB-1:0]    addr_we,
   input  logic [NB-1:0]    len_we,
   input  logic [7:0]       wdata,
   input  logic             step,
   output logic [PTR_W-1:0] cur_addr,
   output logic [PTR_W-1:0] cur_len,
   output logic             len_zero
);

   logic [PTR_W-1:0] addr_nx, len_nx, addr_d, len_d;

   // stepping happens only while running, lane writes only while idle
   assign addr_nx = step ? cur_addr + PTR_W'(STEP) : cur_addr;
   assign len_nx  = step ? cur_len - PTR_W'(1)     : cur_len;

   for (genvar i = 0; i < NB; i++) begin : g_lane
      assign addr_d[8*i +: 8] = addr_we[i] ? wdata : addr_nx[8*i +: 8];
      assign len_d[8*i +: 8]  = len_we[i]  ? wdata : len_nx[8*i +: 8];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_addr <= '0;
         cur_len  <= '0;
      end else begin
         cur_addr <= addr_d;
         cur_len  <= len_d;
      end
   end

   assign len_zero = (cur_len == '0);

endmodule

// File: rtl/bmd_xfer_fsm.sv
module bmd_xfer_fsm import bmd_pkg::*; #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop_req,
   input  logic              dir_m2d,
   input  logic              len_zero,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              snk_valid,
   output logic [DATA_W-1:0] snk_data,
   input  logic              snk_ready,
   output logic              step,
   output logic              done,
   output logic              busy
);

   xfer_state_t st, nx;
   logic [DATA_W-1:0] word_q;
   logic load_src, load_mem;

   always_comb begin
      nx        = st;
      src_ready = 1'b0;
      mem_req   = 1'b0;
      snk_valid = 1'b0;
      step      = 1'b0;
      done      = 1'b0;
      load_src  = 1'b0;
      load_mem  = 1'b0;
      unique case (st)
         XS_IDLE: if (start) nx = XS_DECIDE;
         XS_DECIDE: begin
            if (len_zero) begin
               done = 1'b1;
               nx   = XS_IDLE;
            end else if (stop_req) nx = XS_IDLE;
            else if (dir_m2d)      nx = XS_MEM;
            else                   nx = XS_FETCH;
         end
         XS_FETCH: begin
            if (stop_req) nx = XS_IDLE;
            else begin
               src_ready = 1'b1;
               if (src_valid) begin
                  load_src = 1'b1;
                  nx       = XS_MEM;
               end
            end
         end
         XS_MEM: begin
            mem_req = 1'b1;
            if (mem_ack) begin
               if (dir_m2d) begin
                  load_mem = 1'b1;
                  nx       = XS_DELIVER;
               end else begin
                  step = 1'b1;
                  nx   = XS_DECIDE;
               end
            end
         end
         XS_DELIVER: begin
            snk_valid = 1'b1;
            if (snk_ready) begin
               step = 1'b1;
               nx   = XS_DECIDE;
            end
         end
         default: nx = XS_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= XS_IDLE;
         word_q <= '0;
      end else begin
         st <= nx;
         if (load_src)      word_q <= src_data;
         else if (load_mem) word_q <= mem_rdata;
      end
   end

   assign mem_we    = mem_req && !dir_m2d;
   assign mem_wdata = word_q;
   assign snk_data  = word_q;
   assign busy      = (st != XS_IDLE);

endmodule

// File: rtl/bm_dma_engine.sv
module bm_dma_engine import bmd_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int PTR_W  = 32,
   parameter int REG_AW = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              mem_req,
   output logic              mem_we,
   output logic [PTR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   output logic              snk_valid,
   output logic [DATA_W-1:0] snk_data,
   input  logic              snk_ready
);

   localparam int NB = PTR_W / 8;
   localparam int WB = DATA_W / 8;

   if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
      $error("DATA_W must be a whole number of bytes");
   end
   if (PTR_W % 8 != 0 || PTR_W < 16 || PTR_W > 32) begin : g_bad_ptr
      $error("PTR_W must be 16, 24 or 32");
   end
   if (LEN_OFS + NB > (1 << REG_AW)) begin : g_bad_aw
      $error("REG_AW too small for the register window");
   end

   logic start, stop_req, dir_m2d, cfg_open, busy, done, step, len_zero;
   logic [NB-1:0] addr_we, len_we;
   logic [PTR_W-1:0] cur_addr, cur_len;

   bmd_ctl_regs #(.REG_AW(REG_AW), .PTR_W(PTR_W)) u_ctl (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .busy(busy), .done(done), .start(start),
      .stop_req(stop_req), .dir_m2d(dir_m2d), .cfg_open(cfg_open), .irq(irq),
      .addr_we(addr_we), .len_we(len_we)
   );

   bmd_ptr_regs #(.PTR_W(PTR_W), .STEP(WB)) u_ptr (
      .clk(clk), .rst_n(rst_n), .addr_we(addr_we), .len_we(len_we),
      .wdata(reg_wdata), .step(step), .cur_addr(cur_addr), .cur_len(cur_len),
      .len_zero(len_zero)
   );

   bmd_xfer_fsm #(.DATA_W(DATA_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .stop_req(stop_req),
      .dir_m2d(dir_m2d), .len_zero(len_zero), .src_valid(src_valid),
      .src_data(src_data), .src_ready(src_ready), .mem_req(mem_req),
      .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .snk_valid(snk_valid), .snk_data(snk_data),
      .snk_ready(snk_ready), .step(step), .done(done), .busy(busy)
   );

   assign mem_addr = cur_addr;

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == REG_AW'(STAT_OFS)) begin
         reg_rdata[ST_BUSY_BIT] = busy;
         reg_rdata[ST_IRQ_BIT]  = irq;
         reg_rdata[ST_DIR_BIT]  = dir_m2d;
         reg_rdata[ST_OPEN_BIT] = cfg_open;
      end
      for (int i = 0; i < NB; i++) begin
         if (reg_addr == REG_AW'(ADDR_OFS + i)) reg_rdata = cur_addr[8*i +: 8];
         if (reg_addr == REG_AW'(LEN_OFS + i))  reg_rdata = cur_len[8*i +: 8];
      end
   end

endmodule

// File: rtl/bm_dma_engine_chk.sv
module bm_dma_engine_chk import bmd_pkg::*; #(
   parameter int DATA_W = 32,
   parameter int PTR_W  = 32,
   parameter int REG_AW = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [REG_AW-1:0] reg_addr,
   input logic [7:0]        reg_wdata,
   input logic              irq,
   input logic              busy,
   input logic              mem_req,
   input logic              mem_we,
   input logic [PTR_W-1:0]  mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              mem_ack,
   input logic              src_ready,
   input logic              snk_valid,
   input logic [DATA_W-1:0] snk_data,
   input logic              snk_ready
);

   logic irq_clr;
   assign irq_clr = reg_wr && (reg_addr == REG_AW'(STAT_OFS)) && reg_wdata[ST_IRQ_BIT];

   // R5
   mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   // R5
   one_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({src_ready, mem_req, snk_valid}));

   // R6
   snk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snk_valid && !snk_ready |=> snk_valid && $stable(snk_data));

   // R8
   irq_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> !busy);

   // R9
   irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq && !irq_clr |=> irq);

   // R11
   port_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req || src_ready || snk_valid) |-> busy);

endmodule

bind bm_dma_engine bm_dma_engine_chk #(.DATA_W(DATA_W), .PTR_W(PTR_W), .REG_AW(REG_AW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .irq(irq), .busy(busy), .mem_req(mem_req),
   .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_ack(mem_ack), .src_ready(src_ready), .snk_valid(snk_valid),
   .snk_data(snk_data), .snk_ready(snk_ready)
);

// File: tb/tb_bm_dma_engine.sv
module tb_bm_dma_engine;

   localparam int CLK_PERIOD = 10;
   localparam int WD_CYCLES  = 150000;
   localparam int OFS_CMD = 0, OFS_STAT = 1, OFS_ADDR = 4, OFS_LEN = 8;
   localparam logic [7:0] C_STOP = 8'h01, C_GO = 8'h02, C_TOMEM = 8'h04, C_FROMMEM = 8'h08;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic [3:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic irq, mem_req, mem_we, mem_ack = 1'b0;
   logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
   logic src_valid = 1'b0, src_ready;
   logic [31:0] src_data = '0;
   logic snk_valid, snk_ready = 1'b0;
   logic [31:0] snk_data;

   int n_chk = 0, n_fail = 0;

   logic [31:0] mem_model [256];
   logic [31:0] src_words [64];
   logic [31:0] exp_words [64];
   logic [31:0] sink_got [64];
   int src_n = 0, src_idx = 0, sink_n = 0, acc_cnt = 0, addr_err = 0, mwait = 0;
   logic [31:0] exp_next_addr = '0;
   bit sink_slow = 0;
   bit src_rdy_seen = 0, snk_v_seen = 0;
   logic [31:0] snk_d_seen = '0;

   bm_dma_engine #(.DATA_W(32), .PTR_W(32), .REG_AW(4)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
      .snk_valid(snk_valid), .snk_data(snk_data), .snk_ready(snk_ready)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [31:0] end_addr(logic [31:0] base, int n);
      return base + 32'(n * 4);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // memory responder
   initial forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (rst_n && mem_req) begin
         if (mwait == 0) begin
            if (mem_addr !== exp_next_addr) addr_err++;
            exp_next_addr = exp_next_addr + 32'd4;
            if (mem_we) mem_model[mem_addr[9:2]] = mem_wdata;
            else        mem_rdata = mem_model[mem_addr[9:2]];
            mem_ack = 1'b1;
            acc_cnt++;
            mwait = $urandom % 3;
         end else mwait--;
      end
   end

   // source model
   initial forever begin
      @(negedge clk);
      if (src_valid && src_rdy_seen) src_idx++;
      src_valid = (src_idx < src_n) && ($urandom % 4 != 0);
      src_data  = src_words[src_idx % 64];
      src_rdy_seen = src_ready;
   end

   // sink model
   initial forever begin
      @(negedge clk);
      if (snk_v_seen && snk_ready) begin
         sink_got[sink_n % 64] = snk_d_seen;
         sink_n++;
      end
      snk_ready  = sink_slow ? ($urandom % 4 == 0) : ($urandom % 3 != 0);
      snk_v_seen = snk_valid;
      snk_d_seen = snk_data;
   end

   // watchdog
   initial begin
      repeat (WD_CYCLES) @(posedge clk);
      n_fail++;
      $display("FAIL R8: watchdog expired, actual running expected finished");
      summary();
      $finish;
   end

   task automatic wr(input int a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input int a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = 4'(a);
      #1 d = reg_rdata;
   endtask

   task automatic wr32(input int a, input logic [31:0] v);
      for (int i = 0; i < 4; i++) wr(a + i, v[8*i +: 8]);
   endtask

   task automatic rd32(input int a, output logic [31:0] v);
      logic [7:0] b;
      for (int i = 0; i < 4; i++) begin
         rd(a + i, b);
         v[8*i +: 8] = b;
      end
   endtask

   task automatic wait_idle();
      logic [7:0] st;
      for (int k = 0; k < 5000; k++) begin
         rd(OFS_STAT, st);
         if (!st[0]) return;
      end
      chk("R11 engine stuck busy", 32'(st[0]), 32'd0);
   endtask

   task automatic setup(input bit m2d, input logic [31:0] base, input int n, input int src_avail);
      wr(OFS_CMD, C_STOP);
      wr(OFS_CMD, m2d ? C_FROMMEM : C_TOMEM);
      wr32(OFS_ADDR, base);
      wr32(OFS_LEN, 32'(n));
      for (int i = 0; i < n && i < 64; i++) begin
         src_words[i] = $urandom;
         exp_words[i] = $urandom;
         if (m2d) mem_model[(base >> 2) + 32'(i)] = exp_words[i];
      end
      exp_next_addr = base; addr_err = 0; acc_cnt = 0; sink_n = 0;
      src_idx = 0; src_n = m2d ? 0 : src_avail;
   endtask

   task automatic finish_check(input bit m2d, input logic [31:0] base, input int n);
      logic [31:0] v;
      wait_idle();
      chk("R8 irq after completion", 32'(irq), 32'd1);
      rd32(OFS_ADDR, v); chk("R7 final address", v, end_addr(base, n));
      rd32(OFS_LEN, v);  chk("R7 final length", v, 32'd0);
      chk("R7 address sequence errors", 32'(addr_err), 32'd0);
      chk("R5 R6 memory access count", 32'(acc_cnt), 32'(n));
      if (m2d) begin
         chk("R6 words delivered", 32'(sink_n), 32'(n));
         for (int i = 0; i < n; i++) chk("R6 sink word", sink_got[i], exp_words[i]);
      end else begin
         for (int i = 0; i < n; i++) chk("R5 stored word", mem_model[(base >> 2) + 32'(i)], src_words[i]);
      end
      wr(OFS_STAT, 8'h02);
      chk("R9 irq cleared", 32'(irq), 32'd0);
   endtask

   initial begin
      logic [7:0] st;
      logic [31:0] v, rem;
      void'($urandom(32'h5EED_1234));
      for (int i = 0; i < 256; i++) mem_model[i] = $urandom;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 irq", 32'(irq), 32'd0);
      chk("R1 mem_req", 32'(mem_req), 32'd0);
      chk("R1 src_ready", 32'(src_ready), 32'd0);
      chk("R1 snk_valid", 32'(snk_valid), 32'd0);
      rd(OFS_STAT, st); chk("R1 status", 32'(st), 32'd0);
      rd32(OFS_ADDR, v); chk("R1 address", v, 32'd0);
      rd32(OFS_LEN, v);  chk("R1 length", v, 32'd0);

      // R3 config closed after reset, R4 go ignored
      wr32(OFS_ADDR, 32'h1234_5678);
      rd32(OFS_ADDR, v); chk("R3 address write before stop", v, 32'd0);
      wr(OFS_CMD, C_FROMMEM);
      wr(OFS_CMD, C_GO);
      rd(OFS_STAT, st); chk("R4 R3 go before stop ignored", 32'(st), 32'd0);

      // R2 little-endian lanes, R11 open bit
      wr(OFS_CMD, C_STOP);
      rd(OFS_STAT, st); chk("R11 open bit", 32'(st), 32'h08);
      wr32(OFS_ADDR, 32'hA1B2_C3D4);
      rd(OFS_ADDR, st);     chk("R2 lowest lane", 32'(st), 32'hD4);
      rd(OFS_ADDR + 3, st); chk("R2 highest lane", 32'(st), 32'hA1);
      wr(OFS_LEN + 1, 8'h5A);
      rd32(OFS_LEN, v); chk("R2 length lane 1", v, 32'h0000_5A00);

      // R12 unknown codes
      wr(OFS_CMD, 8'h55);
      wr(OFS_CMD, 8'h00);
      rd(OFS_STAT, st); chk("R12 unknown codes", 32'(st), 32'h08);
      wr(OFS_CMD, C_FROMMEM);
      rd(OFS_STAT, st); chk("R11 direction bit", 32'(st), 32'h0C);

      // R8 zero length, exact timing
      setup(0, 32'h40, 0, 0);
      wr(OFS_CMD, C_GO);
      chk("R8 irq not yet on go edge", 32'(irq), 32'd0);
      @(negedge clk);
      chk("R8 zero length irq", 32'(irq), 32'd1);
      chk("R8 zero length no access", 32'(acc_cnt), 32'd0);
      wr(OFS_STAT, 8'h00);
      chk("R9 write without bit 1 keeps irq", 32'(irq), 32'd1);
      wr(OFS_STAT, 8'h02);
      chk("R9 clear", 32'(irq), 32'd0);

      // directed memory-write run with lane carry
      setup(0, 32'hFC, 5, 5);
      wr(OFS_CMD, C_GO);
      finish_check(0, 32'hFC, 5);

      // directed memory-read run
      setup(1, 32'h300, 6, 0);
      wr(OFS_CMD, C_GO);
      finish_check(1, 32'h300, 6);

      // R4 go while busy and R3 address write while busy
      sink_slow = 1;
      setup(1, 32'h80, 8, 0);
      wr(OFS_CMD, C_GO);
      rd(OFS_STAT, st); chk("R11 busy while running", 32'(st[0]), 32'd1);
      wr(OFS_CMD, C_GO);
      wr(OFS_ADDR, 8'h00);
      finish_check(1, 32'h80, 8);
      wr(OFS_CMD, C_GO);
      @(negedge clk);
      rd(OFS_STAT, st); chk("R4 go after completion ignored", 32'(st), 32'h04);
      chk("R4 no access after ignored go", 32'(acc_cnt), 32'd8);

      // R10 stop during a memory-read run
      setup(1, 32'h200, 30, 0);
      wr(OFS_CMD, C_GO);
      repeat (20) @(negedge clk);
      wr(OFS_CMD, C_STOP);
      wait_idle();
      repeat (2) @(negedge clk);
      chk("R10 no irq on stop", 32'(irq), 32'd0);
      rd32(OFS_LEN, rem);
      chk("R10 remaining plus delivered", rem + 32'(sink_n), 32'd30);
      chk("R10 stopped early", 32'(sink_n < 30), 32'd1);
      chk("R10 reads equal deliveries", 32'(acc_cnt), 32'(sink_n));
      rd32(OFS_ADDR, v); chk("R10 next address", v, end_addr(32'h200, sink_n));
      sink_slow = 0;

      // R10 stop while waiting for a dry source
      setup(0, 32'h20, 4, 0);
      wr(OFS_CMD, C_GO);
      repeat (5) @(negedge clk);
      wr(OFS_CMD, C_STOP);
      wait_idle();
      chk("R10 dry source no irq", 32'(irq), 32'd0);
      rd32(OFS_LEN, v); chk("R10 dry source length kept", v, 32'd4);
      chk("R10 dry source no access", 32'(acc_cnt), 32'd0);

      // constrained random runs
      for (int it = 0; it < 8; it++) begin
         bit dir;
         int n;
         logic [31:0] base;
         dir  = 1'($urandom % 2);
         n    = $urandom % 13;
         base = ($urandom % 128) * 4;
         setup(dir, base, n, n);
         wr(OFS_CMD, C_GO);
         finish_check(dir, base, n);
      end

      summary();
      $finish;
   end

endmodule